// File: doc/BRIEF.md
# Matrix LRU Tracker

This block keeps the exact least-recently-used order among a set of page frames so that a replacement engine always has a victim ready. It stores one bit per ordered pair of frames in a square bit matrix. When frame k is referenced, the matrix marks k as more recent than every other frame in one clock cycle. The frame whose row, read as an unsigned number, is smallest is the one that has gone longest without a reference, and that frame is presented on the victim output.

A client pulses a reference strobe with a frame index each time a frame is touched, and may wipe the history with a synchronous clear. The victim index is combinational from the stored matrix, so it always shows the state left by the last clock edge. The number of frames is a parameter with a default of 4.

Top module: `lru_matrix_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `victim_frame` is 0 and `victim_vld` is 0, because every matrix bit is cleared.
- R2: A reference (`ref_vld` high, `clr` low) to frame k makes k the most recent frame, so from the next cycle on `victim_frame` differs from k (for two or more frames).
- R3: After any sequence of references, `victim_frame` is the frame (binary index) whose most recent reference is the oldest; within a row, bit 0 is the least significant bit and a referenced row holds ones in every column except its own.
- R4: Frames that have not been referenced since reset or clear rank below all referenced frames, and among several such frames the lowest index is reported.
- R5: With 4 frames, the reference order 0,1,2,3,2,1,0,3,2,3 leaves `victim_frame` equal to 1.
- R6: `clr` high returns the matrix to its reset state on the next cycle; a reference presented in the same cycle as `clr` is discarded.
- R7: `victim_vld` is 0 until the first reference after reset or clear and is 1 in every cycle after it until the next clear or reset.
- R8: Referencing the same frame several times in a row leaves the order of the other frames unchanged.
- R9: `victim_frame` and `victim_vld` change only on the clock edge that accepts a reference or a clear: in the cycle a reference is presented they still show the earlier state, and idle cycles leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous history wipe, wins over a reference in the same cycle |
| ref_vld | input | 1 | A frame reference is presented this cycle |
| ref_frame | input | IDXW | Binary index of the referenced frame |
| victim_frame | output | IDXW | Binary index of the least recently used frame |
| victim_vld | output | 1 | At least one reference recorded since reset or clear |

## Verification
Two update functions meet in one cycle in this block: the row set and the column clear of the same reference land on the diagonal bit, and a wipe can arrive together with a reference. The bench provokes the first on every reference and the second both in a directed case and through random clears mixed into a random reference stream, judging each by comparing the victim against a recency-stamp model that is free of any matrix. The checker adds that the referenced row carries exactly one fewer one than the frame count and that its column is empty, which catches a diagonal left set, and that a wipe leaves an all-zero matrix whatever reference came with it.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Update applied to the matrix on a clock edge
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_WIPE  = 2'd1,
        UPD_TOUCH = 2'd2
    } upd_e;

    // Width of a frame index for n frames (at least one bit)
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // True when a frame index names an existing frame
    function automatic logic frame_ok(input int unsigned idx, input int unsigned n);
        return idx < n;
    endfunction

    // Choose the update for this cycle; a wipe dominates a reference
    function automatic upd_e pick_update(input logic wipe, input logic touch_req,
                                         input logic in_range);
        upd_e op;
        op = UPD_HOLD;
        if (wipe)
            op = UPD_WIPE;
        else if (touch_req && in_range)
            op = UPD_TOUCH;
        return op;
    endfunction

endpackage

// File: rtl/lru_bit_matrix.sv
module lru_bit_matrix
    import lru_pkg::*;
#(
    parameter int N    = 4,
    parameter int IDXW = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  upd_e                      op,
    input  logic [IDXW-1:0]           frame,
    output logic [N-1:0][N-1:0]       rows
);

    // One register row per frame; row r bit c set means r is newer than c
    for (genvar r = 0; r < N; r++) begin : g_row
        localparam logic [IDXW-1:0] RIDX = IDXW'(r);
        logic [N-1:0] row_q;
        logic [N-1:0] row_d;

        always_comb begin
            row_d = row_q;
            unique case (op)
                UPD_WIPE: row_d = '0;
                UPD_TOUCH: begin
                    if (frame == RIDX)
                        row_d = '1;
                    // column clear applied after the row set, so it wins
                    row_d[frame] = 1'b0;
                end
                default: row_d = row_q;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst)
                row_q <= '0;
            else
                row_q <= row_d;
        end

        assign rows[r] = row_q;
    end

endmodule

// File: rtl/lru_min_tree.sv
module lru_min_tree #(
    parameter int N    = 4,
    parameter int IDXW = 2
) (
    input  logic [N-1:0][N-1:0] rows,
    output logic [IDXW-1:0]     min_idx
);

    localparam int LEAVES = 1 << IDXW;

    // Level 0 holds the leaves; level IDXW is the root
    for (genvar l = 0; l <= IDXW; l++) begin : g_lvl
        localparam int NODES = LEAVES >> l;
        for (genvar n = 0; n < NODES; n++) begin : g_node
            logic [N-1:0]    v;
            logic [IDXW-1:0] ix;
            if (l == 0) begin : g_leaf
                if (n < N) begin : g_real
                    assign v = rows[n];
                end else begin : g_pad
                    // a real row always has a zero diagonal, so padding never wins
                    assign v = '1;
                end
                assign ix = IDXW'(n);
            end else begin : g_cmp
                logic take_hi;
                // strict compare: on a tie the lower-index child is kept
                assign take_hi = g_lvl[l-1].g_node[2*n+1].v < g_lvl[l-1].g_node[2*n].v;
                assign v  = take_hi ? g_lvl[l-1].g_node[2*n+1].v  : g_lvl[l-1].g_node[2*n].v;
                assign ix = take_hi ? g_lvl[l-1].g_node[2*n+1].ix : g_lvl[l-1].g_node[2*n].ix;
            end
        end
    end

    assign min_idx = g_lvl[IDXW].g_node[0].ix;

endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker
    import lru_pkg::*;
#(
    parameter  int N_FRAMES = 4,
    localparam int IDXW     = lru_pkg::idx_bits(N_FRAMES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            ref_vld,
    input  logic [IDXW-1:0] ref_frame,
    output logic [IDXW-1:0] victim_frame,
    output logic            victim_vld
);

    upd_e                             op;
    logic [N_FRAMES-1:0][N_FRAMES-1:0] mat_rows;

    assign op = pick_update(clr, ref_vld, frame_ok(int'(ref_frame), N_FRAMES));

    lru_bit_matrix #(
        .N    (N_FRAMES),
        .IDXW (IDXW)
    ) u_matrix (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .frame (ref_frame),
        .rows  (mat_rows)
    );

    lru_min_tree #(
        .N    (N_FRAMES),
        .IDXW (IDXW)
    ) u_min (
        .rows    (mat_rows),
        .min_idx (victim_frame)
    );

    // any set bit means a reference has been recorded since the last wipe
    assign victim_vld = |mat_rows;

endmodule

// File: rtl/lru_tracker_chk.sv
module lru_tracker_chk #(
    parameter int N    = 4,
    parameter int IDXW = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                clr,
    input logic                ref_vld,
    input logic [IDXW-1:0]     ref_frame,
    input logic [N-1:0][N-1:0] rows,
    input logic [IDXW-1:0]     victim_frame,
    input logic                victim_vld
);

    function automatic logic column_empty(input logic [N-1:0][N-1:0] m,
                                          input logic [IDXW-1:0] k);
        logic any;
        any = 1'b0;
        for (int r = 0; r < N; r++)
            any = any | m[r][k];
        return !any;
    endfunction

    function automatic logic diag_empty(input logic [N-1:0][N-1:0] m);
        logic any;
        any = 1'b0;
        for (int r = 0; r < N; r++)
            any = any | m[r][r];
        return !any;
    endfunction

    logic touch;
    assign touch = ref_vld && !clr && (int'(ref_frame) < N);

    // R1: leaving reset, the matrix is empty
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rows == '0 && victim_frame == '0 && !victim_vld));

    // R2: the frame just referenced is never the victim
    assert_touched_not_victim_R2: assert property (@(posedge clk) disable iff (rst)
        touch |=> victim_frame != $past(ref_frame));

    // R3: referenced row has N-1 ones and its column is empty
    assert_row_weight_R3: assert property (@(posedge clk) disable iff (rst)
        touch |=> $countones(rows[$past(ref_frame)]) == N - 1);

    assert_column_clear_R3: assert property (@(posedge clk) disable iff (rst)
        touch |=> column_empty(rows, $past(ref_frame)));

    assert_diag_zero_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> diag_empty(rows));

    // R6: wipe empties the matrix even with a reference alongside
    assert_wipe_empty_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (rows == '0 && !victim_vld));

    // R7: a recorded reference raises the valid flag
    assert_valid_after_ref_R7: assert property (@(posedge clk) disable iff (rst)
        touch |=> victim_vld);

    // R9: idle cycles leave the state alone
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!ref_vld && !clr) |=> ($stable(rows) && $stable(victim_frame)));

endmodule

bind lru_matrix_tracker lru_tracker_chk #(
    .N    (N_FRAMES),
    .IDXW (IDXW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr),
    .ref_vld      (ref_vld),
    .ref_frame    (ref_frame),
    .rows         (mat_rows),
    .victim_frame (victim_frame),
    .victim_vld   (victim_vld)
);

// File: tb/test_lru_matrix_tracker.sv
module test_lru_matrix_tracker;

    localparam int NF = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          ref_vld = 1'b0;
    logic [IW-1:0] ref_frame = '0;
    logic [IW-1:0] victim_frame;
    logic          victim_vld;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // recency model: stamp 0 means not referenced since the last wipe
    int unsigned stamp [NF];
    int unsigned now_t;

    always #5 clk = ~clk;

    lru_matrix_tracker #(.N_FRAMES(NF)) i_lru_matrix_tracker (
        .clk          (clk),
        .rst          (rst),
        .clr          (clr),
        .ref_vld      (ref_vld),
        .ref_frame    (ref_frame),
        .victim_frame (victim_frame),
        .victim_vld   (victim_vld)
    );

    function automatic int exp_victim();
        int best = 0;
        for (int i = 1; i < NF; i++)
            if (stamp[i] < stamp[best]) best = i;
        return best;
    endfunction

    function automatic bit exp_valid();
        bit any = 1'b0;
        for (int i = 0; i < NF; i++)
            if (stamp[i] != 0) any = 1'b1;
        return any;
    endfunction

    task automatic model_wipe();
        for (int i = 0; i < NF; i++) stamp[i] = 0;
        now_t = 0;
    endtask

    task automatic check(input string tag);
        n_checks++;
        if (int'(victim_frame) != exp_victim() || victim_vld != exp_valid()) begin
            n_fails++;
            $display("FAIL %s: victim=%0d vld=%0d expected victim=%0d vld=%0d",
                     tag, victim_frame, victim_vld, exp_victim(), exp_valid());
        end
    endtask

    task automatic check_value(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: present inputs, verify nothing moves before the edge, update
    task automatic step(input bit v, input int f, input bit c, input bit pre_chk);
        @(negedge clk);
        ref_vld   = v;
        ref_frame = IW'(f);
        clr       = c;
        #1;
        if (pre_chk) check("R9 output before edge");
        @(posedge clk);
        if (c)
            model_wipe();
        else if (v) begin
            now_t++;
            stamp[f] = now_t;
        end
        #2;
        @(negedge clk);
        ref_vld = 1'b0;
        clr     = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        int seq [10] = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};
        void'($urandom(32'd1729));
        model_wipe();

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1 after reset");

        // R7 / R4: first reference to frame 2; untouched 0 stays victim
        step(1'b1, 2, 1'b0, 1'b1);
        check("R7 valid after first reference");
        check_value("R4 lowest untouched frame", int'(victim_frame), 0);
        step(1'b1, 0, 1'b0, 1'b1);
        check_value("R4 next untouched frame", int'(victim_frame), 1);

        // R2: just touched frame is not the victim
        check("R2 touched frame not victim");

        // R9: idle cycles do not move the output
        step(1'b0, 3, 1'b0, 1'b1);
        check("R9 idle cycle");

        // R6: clear together with a reference
        step(1'b1, 1, 1'b1, 1'b1);
        check("R6 clear wins over reference");
        check_value("R6 valid low after clear", int'(victim_vld), 0);

        // R5: directed sequence
        foreach (seq[i]) step(1'b1, seq[i], 1'b0, 1'b1);
        check_value("R5 directed sequence victim", int'(victim_frame), 1);
        check("R3 directed sequence model");

        // R8: repeated references to one frame
        step(1'b1, 1, 1'b0, 1'b1);
        check("R8 first touch");
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1, 1'b0, 1'b1);
            check("R8 repeated touch");
        end

        // R3: full rotation, then oldest must come back in order
        step(1'b1, 0, 1'b1, 1'b1);
        for (int i = NF - 1; i >= 0; i--) step(1'b1, i, 1'b0, 1'b0);
        check_value("R3 rotation victim", int'(victim_frame), NF - 1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 2)
                step(1'b1, int'($urandom_range(0, NF - 1)), 1'b1, 1'b1);
            else if (r < 85)
                step(1'b1, int'($urandom_range(0, NF - 1)), 1'b0, 1'b1);
            else
                step(1'b0, int'($urandom_range(0, NF - 1)), 1'b0, 1'b1);
            check("R3 random reference stream");
        end

        // R1 again: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_wipe();
        #2;
        check("R1 reset mid-run");

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule